// File: doc/BRIEF.md
# Tagged-Bottom Datapath Slice with Property Monitor

This block is a small word-level datapath in which every signal travels as a word value paired with a one-bit valid flag. A cleared flag marks the signal as bottom, meaning its value is undefined. The slice has three parts, each with fixed rules for how bottom moves through it:

- an operator unit with four operations chosen by a 2-bit code;
- a two-way multiplexer whose select input is itself a tagged signal;
- a monitor that decides whether a tagged one-bit property counts as holding.

The slice is meant for abstract models, where reads from unmodelled storage return bottom. Bottom is then carried forward so that a property check is only judged when its result is defined. Apart from an optional output register stage, chosen by a parameter, all logic is combinational.

Top module: `tagged_dp`

## Requirements
- R1: With both operands valid, the operator result is valid and equals: a+b modulo 2^W for code 00, bitwise AND for code 01, bitwise XOR for code 10, and the equality flag for code 11.
- R2: If either operand's valid flag is 0, the operator result's valid flag is 0 for every code.
- R3: With the select valid, the mux outputs data input 0 when the select value is 0 and data input 1 when it is 1, including that input's valid flag.
- R4: If the select's valid flag is 0, the mux result's valid flag is 0, whatever the data inputs are.
- R5: With the select valid, a bottom selected input gives a bottom result. A bottom unselected input does not change the result.
- R6: The monitor output is 1 exactly when the property valid flag is 0 or the property value is 1.
- R7: With REG_OUT=1, every output appears one clock after its inputs. While rst_ni is low, both result valid flags are 0 and the monitor output is 1.
- R8: For code 11, result bit 0 is 1 iff a equals b, and all higher result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_val_i | input | W | Operand a value |
| a_vld_i | input | 1 | Operand a valid flag |
| b_val_i | input | W | Operand b value |
| b_vld_i | input | 1 | Operand b valid flag |
| opc_i | input | 2 | Operation code (00 add, 01 and, 10 xor, 11 equal) |
| sel_val_i | input | 1 | Mux select value |
| sel_vld_i | input | 1 | Mux select valid flag |
| d0_val_i | input | W | Mux data input 0 value |
| d0_vld_i | input | 1 | Mux data input 0 valid flag |
| d1_val_i | input | W | Mux data input 1 value |
| d1_vld_i | input | 1 | Mux data input 1 valid flag |
| prop_val_i | input | 1 | Property value |
| prop_vld_i | input | 1 | Property valid flag |
| alu_val_o | output | W | Operator result value |
| alu_vld_o | output | 1 | Operator result valid flag |
| mux_val_o | output | W | Mux result value |
| mux_vld_o | output | 1 | Mux result valid flag |
| prop_ok_o | output | 1 | Property treated as holding |

## Verification
The assertions check every cycle that the registered outputs follow the bottom rules:

- a bottom operand kills the operator result;
- a bottom select, or a bottom selected input, kills the mux result;
- a bottom property always passes;
- path 0 of the mux forwards its data;
- an equality result keeps its upper bits at zero.

The arithmetic values themselves are shown only by the bench's scenarios: wrapping addition, AND, XOR and equality. So are path 1 of the mux, the fact that a bottom unselected input has no effect, the reset values and the one-cycle latency. The bench sweeps every combination of valid flags against its own reference model.

// File: rtl/tagged_pkg.sv
package tagged_pkg;
  typedef enum logic [1:0] {
    OPC_ADD = 2'b00,
    OPC_AND = 2'b01,
    OPC_XOR = 2'b10,
    OPC_EQ  = 2'b11
  } opc_e;
endpackage

// File: rtl/tagged_alu.sv
module tagged_alu
  import tagged_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_val_i,
  input  logic         a_vld_i,
  input  logic [W-1:0] b_val_i,
  input  logic         b_vld_i,
  input  logic [1:0]   opc_i,
  output logic [W-1:0] y_val_o,
  output logic         y_vld_o
);
  logic [W-1:0] raw;

  always_comb begin
    unique case (opc_e'(opc_i))
      OPC_ADD: raw = a_val_i + b_val_i;
      OPC_AND: raw = a_val_i & b_val_i;
      OPC_XOR: raw = a_val_i ^ b_val_i;
      default: raw = {{(W-1){1'b0}}, (a_val_i == b_val_i)};
    endcase
  end

  // bottom in -> bottom out; value zeroed to keep bottom words quiet
  assign y_vld_o = a_vld_i & b_vld_i;
  assign y_val_o = y_vld_o ? raw : '0;
endmodule

// File: rtl/tagged_mux.sv
module tagged_mux #(
  parameter int unsigned W = 8
) (
  input  logic         sel_val_i,
  input  logic         sel_vld_i,
  input  logic [W-1:0] d0_val_i,
  input  logic         d0_vld_i,
  input  logic [W-1:0] d1_val_i,
  input  logic         d1_vld_i,
  output logic [W-1:0] y_val_o,
  output logic         y_vld_o
);
  logic [W-1:0] pick_val;
  logic         pick_vld;

  assign pick_val = sel_val_i ? d1_val_i : d0_val_i;
  assign pick_vld = sel_val_i ? d1_vld_i : d0_vld_i;

  // bottom select poisons output regardless of data
  assign y_vld_o = sel_vld_i & pick_vld;
  assign y_val_o = y_vld_o ? pick_val : '0;
endmodule

// File: rtl/tagged_prop_mon.sv
module tagged_prop_mon (
  input  logic p_val_i,
  input  logic p_vld_i,
  output logic ok_o
);
  // undefined property result counts as passing
  assign ok_o = ~p_vld_i | p_val_i;
endmodule

// File: rtl/tagged_dp.sv
module tagged_dp
  import tagged_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_val_i,
  input  logic         a_vld_i,
  input  logic [W-1:0] b_val_i,
  input  logic         b_vld_i,
  input  logic [1:0]   opc_i,
  input  logic         sel_val_i,
  input  logic         sel_vld_i,
  input  logic [W-1:0] d0_val_i,
  input  logic         d0_vld_i,
  input  logic [W-1:0] d1_val_i,
  input  logic         d1_vld_i,
  input  logic         prop_val_i,
  input  logic         prop_vld_i,
  output logic [W-1:0] alu_val_o,
  output logic         alu_vld_o,
  output logic [W-1:0] mux_val_o,
  output logic         mux_vld_o,
  output logic         prop_ok_o
);
  logic [W-1:0] alu_val_c, mux_val_c;
  logic         alu_vld_c, mux_vld_c, ok_c;

  tagged_alu #(.W(W)) i_alu (
    .a_val_i (a_val_i),
    .a_vld_i (a_vld_i),
    .b_val_i (b_val_i),
    .b_vld_i (b_vld_i),
    .opc_i   (opc_i),
    .y_val_o (alu_val_c),
    .y_vld_o (alu_vld_c)
  );

  tagged_mux #(.W(W)) i_mux (
    .sel_val_i (sel_val_i),
    .sel_vld_i (sel_vld_i),
    .d0_val_i  (d0_val_i),
    .d0_vld_i  (d0_vld_i),
    .d1_val_i  (d1_val_i),
    .d1_vld_i  (d1_vld_i),
    .y_val_o   (mux_val_c),
    .y_vld_o   (mux_vld_c)
  );

  tagged_prop_mon i_mon (
    .p_val_i (prop_val_i),
    .p_vld_i (prop_vld_i),
    .ok_o    (ok_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        alu_val_o <= '0;
        alu_vld_o <= 1'b0;
        mux_val_o <= '0;
        mux_vld_o <= 1'b0;
        prop_ok_o <= 1'b1;
      end else begin
        alu_val_o <= alu_val_c;
        alu_vld_o <= alu_vld_c;
        mux_val_o <= mux_val_c;
        mux_vld_o <= mux_vld_c;
        prop_ok_o <= ok_c;
      end
    end

    AST_ALU_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !($past(a_vld_i) && $past(b_vld_i)) |-> !alu_vld_o); // R2
    AST_EQ_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alu_vld_o && $past(opc_i) == OPC_EQ) |-> (alu_val_o >> 1) == '0); // R8
    AST_MUX_PICK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(sel_vld_i && !sel_val_i && d0_vld_i) |->
        (mux_vld_o && mux_val_o == $past(d0_val_i))); // R3
    AST_MUX_SEL_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(sel_vld_i) |-> !mux_vld_o); // R4
    AST_MUX_DATA_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(sel_vld_i && (sel_val_i ? !d1_vld_i : !d0_vld_i)) |-> !mux_vld_o); // R5
    AST_PROP_BOTTOM_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(prop_vld_i) |-> prop_ok_o); // R6
  end else begin : g_comb
    assign alu_val_o = alu_val_c;
    assign alu_vld_o = alu_vld_c;
    assign mux_val_o = mux_val_c;
    assign mux_vld_o = mux_vld_c;
    assign prop_ok_o = ok_c;
  end
endmodule

// File: tb/test_tagged_dp.sv
`timescale 1ns/1ps
module test_tagged_dp;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_val = '0, b_val = '0, d0_val = '0, d1_val = '0;
  logic         a_vld = 0, b_vld = 0, sel_val = 0, sel_vld = 0;
  logic         d0_vld = 0, d1_vld = 0, prop_val = 0, prop_vld = 0;
  logic [1:0]   opc = '0;
  logic [W-1:0] alu_val, mux_val;
  logic         alu_vld, mux_vld, prop_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tagged_dp #(.W(W), .REG_OUT(1'b1)) i_tagged_dp (
    .clk_i(clk), .rst_ni(rst_n),
    .a_val_i(a_val), .a_vld_i(a_vld), .b_val_i(b_val), .b_vld_i(b_vld),
    .opc_i(opc), .sel_val_i(sel_val), .sel_vld_i(sel_vld),
    .d0_val_i(d0_val), .d0_vld_i(d0_vld), .d1_val_i(d1_val), .d1_vld_i(d1_vld),
    .prop_val_i(prop_val), .prop_vld_i(prop_vld),
    .alu_val_o(alu_val), .alu_vld_o(alu_vld), .mux_val_o(mux_val),
    .mux_vld_o(mux_vld), .prop_ok_o(prop_ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model expectations, computed at drive time
  int e_alu_val, e_mux_val;
  bit e_alu_vld, e_mux_vld, e_ok;
  int e_opc;

  task automatic model();
    int s;
    e_opc = opc;
    e_alu_vld = a_vld && b_vld;
    case (opc)
      2'd0: s = (int'(a_val) + int'(b_val)) % 256;
      2'd1: s = a_val & b_val;
      2'd2: s = a_val ^ b_val;
      default: s = (a_val == b_val) ? 1 : 0;
    endcase
    e_alu_val = s;
    if (!sel_vld) e_mux_vld = 0;
    else if (sel_val) begin e_mux_vld = d1_vld; e_mux_val = d1_val; end
    else begin e_mux_vld = d0_vld; e_mux_val = d0_val; end
    e_ok = !prop_vld || prop_val;
  endtask

  // drive at negedge, outputs register at posedge, check at next negedge
  task automatic apply_and_check();
    model();
    @(posedge clk);
    @(negedge clk);
    chk(e_alu_vld ? "R1 alu valid" : "R2 alu bottom", alu_vld, e_alu_vld);
    if (e_alu_vld) begin
      if (e_opc == 3) chk("R8 eq result", alu_val, e_alu_val);
      else chk("R1 alu value", alu_val, e_alu_val);
    end
    if (!sel_vld) chk("R4 sel bottom", mux_vld, 0);
    else if (!e_mux_vld) chk("R5 selected bottom", mux_vld, 0);
    else begin
      chk("R3 mux valid", mux_vld, 1);
      chk("R5 R3 mux value", mux_val, e_mux_val);
    end
    chk("R6 monitor", prop_ok, e_ok);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset alu_vld", alu_vld, 0);
    chk("R7 reset mux_vld", mux_vld, 0);
    chk("R7 reset prop_ok", prop_ok, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep of valid flags, select and code
    for (int i = 0; i < 1024; i++) begin
      a_vld   = i[0];
      b_vld   = i[1];
      opc     = i[3:2];
      sel_vld = i[4];
      sel_val = i[5];
      d0_vld  = i[6];
      d1_vld  = i[7];
      prop_vld = i[8];
      prop_val = i[9];
      a_val  = W'($urandom);
      b_val  = (i % 5 == 0) ? a_val : W'($urandom);
      d0_val = W'($urandom);
      d1_val = W'($urandom);
      apply_and_check();
    end

    // R1 wrap corner
    a_vld = 1; b_vld = 1; opc = 2'b00; a_val = 8'hFF; b_val = 8'h02;
    apply_and_check();
    chk("R1 add wraps", alu_val, 1);
    // R8 equal and unequal
    opc = 2'b11; a_val = 8'hA5; b_val = 8'hA5;
    apply_and_check();
    chk("R8 eq true", alu_val, 1);
    b_val = 8'hA4;
    apply_and_check();
    chk("R8 eq false", alu_val, 0);
    // R5 unselected bottom has no effect
    sel_vld = 1; sel_val = 1; d1_vld = 1; d1_val = 8'h3C; d0_vld = 0;
    apply_and_check();
    chk("R5 unselected bottom ignored", mux_val, 8'h3C);
    // R7 one-cycle latency: change input, sample before the next edge
    sel_val = 0; d0_vld = 1; d0_val = 8'h11;
    chk("R7 output holds before edge", mux_val, 8'h3C);
    @(posedge clk); @(negedge clk);
    chk("R7 output after one edge", mux_val, 8'h11);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule